// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block keeps track of the exclusive-access reservation held by one processor in a shared-memory system. A load-exclusive arms the monitor. A later store-exclusive asks whether its write may proceed. The monitor answers pass or fail one cycle later and then returns to the open state. Each request carries a physical address, an access size code and a shareability flag.

A shareable load-exclusive keeps the full physical address and the size as a comparison tag. A non-shareable load-exclusive keeps only a bare "outstanding" flag and the size. Writes by other agents reach the block as a snoop address. A snoop clears a tagged reservation when it lands in the same 8-byte granule as the tag. A clear input, used for example on context switch or exception entry, drops any reservation at once.

Top module: `excl_monitor`

## Requirements
- R1: A size-aligned shareable load-exclusive arms a tagged reservation. A following shareable store-exclusive with the same address and size passes. Size codes on `req_size` are 0 byte, 1 halfword, 2 word and 3 doubleword. `req_store` is 0 for load-exclusive and 1 for store-exclusive.
- R2: A new load-exclusive replaces any earlier reservation, so only the most recent load-exclusive's address can pass.
- R3: A store-exclusive whose address differs from the tagged address fails.
- R4: A store-exclusive whose size code differs from the reserving load-exclusive's size code fails.
- R5: A non-shareable load-exclusive sets only an outstanding flag. A non-shareable store-exclusive of the same size then passes without any address comparison. A store whose shareability differs from the reservation's shareability fails.
- R6: `resp_valid` is high exactly one cycle after a store-exclusive request, with `resp_fail` 0 for success and 1 for failure. A load-exclusive produces no response.
- R7: Every store-exclusive, whether it passes or fails, leaves the monitor open, so a repeated store fails.
- R8: A snoop whose address lies in the tagged reservation's 8-byte aligned granule clears it. A snoop outside that granule has no effect, and a snoop never affects an outstanding flag. A store-exclusive in the same cycle as a clearing snoop fails.
- R9: `clr_excl` opens the monitor. It overrides a load-exclusive in the same cycle and makes a same-cycle store-exclusive fail.
- R10: While reset is asserted `resp_valid` is 0. After reset the monitor is open, so a store-exclusive fails.
- R11: A load-exclusive whose address is not a multiple of its access size leaves the monitor open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Exclusive request present this cycle |
| req_store | input | 1 | 0 load-exclusive, 1 store-exclusive |
| req_addr | input | ADDR_W | Physical address of the request |
| req_size | input | 2 | Access size code |
| req_shared | input | 1 | Address is marked shareable |
| snoop_valid | input | 1 | Another agent wrote snoop_addr |
| snoop_addr | input | ADDR_W | Address written by another agent |
| clr_excl | input | 1 | Drop any reservation |
| resp_valid | output | 1 | Store-exclusive result valid |
| resp_fail | output | 1 | 0 write allowed, 1 write refused |

## Verification
The assertions assume that request inputs are driven to known values whenever reset is released. They also assume that a store-exclusive result is read only in the cycle where `resp_valid` is high. The stimulus keeps to at most one request per cycle. Snoops and clears are allowed to coincide with any request. The random phase draws addresses from a small pool of aligned and misaligned values in neighbouring granules, so that exact matches, granule hits and misses all occur often.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    MON_OPEN   = 2'd0,
    MON_TAGGED = 2'd1,
    MON_FLAG   = 2'd2
  } mon_kind_e;
endpackage

// File: rtl/excl_align_chk.sv
module excl_align_chk
  import excl_mon_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  acc_size_e         size,
  output logic              aligned
);
  always_comb begin
    unique case (size)
      SZ_BYTE:  aligned = 1'b1;
      SZ_HALF:  aligned = (addr[0] == 1'b0);
      SZ_WORD:  aligned = (addr[1:0] == 2'b00);
      default:  aligned = (addr[2:0] == 3'b000);
    endcase
  end
endmodule

// File: rtl/excl_snoop_match.sv
module excl_snoop_match
  import excl_mon_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int GRAN_LG2 = 3
) (
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  mon_kind_e         kind,
  input  logic [ADDR_W-1:0] tag_addr,
  output logic              hit
);
  localparam int HI = ADDR_W - 1;

  logic same_granule;
  assign same_granule = (snoop_addr[HI:GRAN_LG2] == tag_addr[HI:GRAN_LG2]);
  assign hit          = snoop_valid && (kind == MON_TAGGED) && same_granule;
endmodule

// File: rtl/excl_state.sv
module excl_state
  import excl_mon_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              ld_en,
  input  logic              st_en,
  input  logic              snoop_hit,
  input  logic              ld_shared,
  input  logic              ld_aligned,
  input  logic [ADDR_W-1:0] ld_addr,
  input  acc_size_e         ld_size,
  output mon_kind_e         kind_q,
  output logic [ADDR_W-1:0] tag_q,
  output acc_size_e         size_q
);
  mon_kind_e kind_d;
  logic      tag_en;
  logic      size_en;

  always_comb begin
    kind_d  = kind_q;
    tag_en  = 1'b0;
    size_en = 1'b0;
    if (clr) begin
      kind_d = MON_OPEN;
    end else if (ld_en) begin
      if (ld_aligned) begin
        kind_d  = ld_shared ? MON_TAGGED : MON_FLAG;
        tag_en  = ld_shared;
        size_en = 1'b1;
      end else begin
        kind_d = MON_OPEN;
      end
    end else if (st_en || snoop_hit) begin
      kind_d = MON_OPEN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= MON_OPEN;
      tag_q  <= '0;
      size_q <= SZ_BYTE;
    end else begin
      kind_q <= kind_d;
      if (tag_en)  tag_q  <= ld_addr;
      if (size_en) size_q <= ld_size;
    end
  end

  // R5
  flag_on_nonshared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ld_en && !clr && ld_aligned && !ld_shared) |-> kind_q == MON_FLAG);

  // R11
  misaligned_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ld_en && !ld_aligned) |-> kind_q == MON_OPEN);
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_mon_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int GRAN_LG2 = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_shared,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              clr_excl,
  output logic              resp_valid,
  output logic              resp_fail
);
  acc_size_e         size_in;
  logic              ld_en, st_en, aligned, snoop_hit;
  mon_kind_e         kind_q;
  logic [ADDR_W-1:0] tag_q;
  acc_size_e         size_q;
  logic              match_tag, match_flag, pass;

  assign size_in = acc_size_e'(req_size);
  assign ld_en   = req_valid && !req_store;
  assign st_en   = req_valid && req_store;

  excl_align_chk #(.ADDR_W(ADDR_W)) u_align (
    .addr(req_addr), .size(size_in), .aligned(aligned)
  );

  excl_snoop_match #(.ADDR_W(ADDR_W), .GRAN_LG2(GRAN_LG2)) u_snoop (
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .kind(kind_q), .tag_addr(tag_q), .hit(snoop_hit)
  );

  excl_state #(.ADDR_W(ADDR_W)) u_state (
    .clk(clk), .rst_n(rst_n), .clr(clr_excl), .ld_en(ld_en), .st_en(st_en),
    .snoop_hit(snoop_hit), .ld_shared(req_shared), .ld_aligned(aligned),
    .ld_addr(req_addr), .ld_size(size_in),
    .kind_q(kind_q), .tag_q(tag_q), .size_q(size_q)
  );

  assign match_tag  = (kind_q == MON_TAGGED) && req_shared &&
                      (req_addr == tag_q) && (size_in == size_q);
  assign match_flag = (kind_q == MON_FLAG) && !req_shared && (size_in == size_q);
  assign pass       = (match_tag || match_flag) && !clr_excl && !snoop_hit;

  logic resp_valid_q, resp_fail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid_q <= 1'b0;
      resp_fail_q  <= 1'b1;
    end else begin
      resp_valid_q <= st_en;
      if (st_en) resp_fail_q <= !pass;
    end
  end

  assign resp_valid = resp_valid_q;
  assign resp_fail  = resp_fail_q;

  // R6
  resp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid == $past(req_valid && req_store));

  // R7
  store_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st_en) && !$past(ld_en) |-> kind_q == MON_OPEN);

  // R9
  clear_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && $past(clr_excl) |-> resp_fail);

  // R8
  snoop_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && $past(snoop_hit) |-> resp_fail);

  // R10
  pass_needs_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_fail |-> $past(kind_q) != MON_OPEN);
endmodule

// File: tb/excl_monitor_tb.sv
module excl_monitor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, req_shared = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        snoop_valid = 1'b0;
  logic [31:0] snoop_addr = '0;
  logic        clr_excl = 1'b0;
  logic        resp_valid, resp_fail;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  excl_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_addr(req_addr), .req_size(req_size), .req_shared(req_shared),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .clr_excl(clr_excl),
    .resp_valid(resp_valid), .resp_fail(resp_fail)
  );

  // Behavioural reference: 0 open, 1 tagged, 2 flag only
  int          m_kind;
  logic [31:0] m_addr;
  logic [1:0]  m_size;
  logic        e_valid = 1'b0, e_fail = 1'b1;

  always @(posedge clk or negedge rst_n) begin
    bit hit, ok;
    if (!rst_n) begin
      m_kind = 0; m_addr = '0; m_size = '0; e_valid = 1'b0; e_fail = 1'b1;
    end else begin
      hit = snoop_valid && m_kind == 1 && (snoop_addr >> 3) == (m_addr >> 3);
      e_valid = req_valid && req_store;
      if (e_valid) begin
        ok = (m_kind == 1 && req_shared && req_addr == m_addr && req_size == m_size) ||
             (m_kind == 2 && !req_shared && req_size == m_size);
        e_fail = !(ok && !clr_excl && !hit);
      end
      if (clr_excl) m_kind = 0;
      else if (req_valid && !req_store) begin
        if ((req_addr & ((32'd1 << req_size) - 32'd1)) == 32'd0) begin
          m_kind = req_shared ? 1 : 2;
          if (req_shared) m_addr = req_addr;
          m_size = req_size;
        end else m_kind = 0;
      end else if (e_valid || hit) m_kind = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (resp_valid !== e_valid) begin
        errors++;
        $display("FAIL R6 model resp_valid actual %0b expected %0b", resp_valid, e_valid);
      end else if (e_valid && resp_fail !== e_fail) begin
        errors++;
        $display("FAIL R6 model resp_fail actual %0b expected %0b", resp_fail, e_fail);
      end
    end
  end

  task automatic op(input bit st, input logic [31:0] a, input logic [1:0] sz,
                    input bit sh, input bit snv, input logic [31:0] sna, input bit clr);
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_addr = a; req_size = sz; req_shared = sh;
    snoop_valid = snv; snoop_addr = sna; clr_excl = clr;
    @(negedge clk);
    req_valid = 1'b0; snoop_valid = 1'b0; clr_excl = 1'b0;
  endtask

  task automatic ld(input logic [31:0] a, input logic [1:0] sz, input bit sh);
    op(1'b0, a, sz, sh, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic expect_resp(input bit exp_fail, input string tag);
    checks++;
    if (resp_valid !== 1'b1 || resp_fail !== exp_fail) begin
      errors++;
      $display("FAIL %s valid/fail actual %0b/%0b expected 1/%0b",
               tag, resp_valid, resp_fail, exp_fail);
    end
  endtask

  task automatic stc(input logic [31:0] a, input logic [1:0] sz, input bit sh,
                     input bit exp_fail, input string tag);
    op(1'b1, a, sz, sh, 1'b0, 32'h0, 1'b0);
    expect_resp(exp_fail, tag);
  endtask

  task automatic snoop(input logic [31:0] a);
    @(negedge clk); snoop_valid = 1'b1; snoop_addr = a;
    @(negedge clk); snoop_valid = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (resp_valid !== 1'b0) begin
      errors++; $display("FAIL R10 reset resp_valid actual %0b expected 0", resp_valid);
    end
    rst_n = 1'b1;
    stc(32'h100, 2'd2, 1'b1, 1'b1, "R10 store after reset");
    ld(32'h100, 2'd2, 1'b1);
    checks++;
    if (resp_valid !== 1'b0) begin
      errors++; $display("FAIL R6 load gave response actual %0b expected 0", resp_valid);
    end
    stc(32'h100, 2'd2, 1'b1, 1'b0, "R1 matching store");
    stc(32'h100, 2'd2, 1'b1, 1'b1, "R7 repeated store");
    ld(32'h100, 2'd2, 1'b1); stc(32'h104, 2'd2, 1'b1, 1'b1, "R3 other address");
    ld(32'h100, 2'd2, 1'b1); ld(32'h200, 2'd2, 1'b1);
    stc(32'h100, 2'd2, 1'b1, 1'b1, "R2 older address");
    ld(32'h100, 2'd2, 1'b1); ld(32'h200, 2'd2, 1'b1);
    stc(32'h200, 2'd2, 1'b1, 1'b0, "R2 newest address");
    ld(32'h100, 2'd2, 1'b1); stc(32'h100, 2'd1, 1'b1, 1'b1, "R4 size differs");
    ld(32'h300, 2'd0, 1'b0); stc(32'h344, 2'd0, 1'b0, 1'b0, "R5 flag store");
    ld(32'h300, 2'd0, 1'b0); stc(32'h300, 2'd0, 1'b1, 1'b1, "R5 shareability differs");
    ld(32'h300, 2'd1, 1'b0); snoop(32'h300);
    stc(32'h300, 2'd1, 1'b0, 1'b0, "R8 snoop ignores flag");
    ld(32'h100, 2'd3, 1'b1); snoop(32'h104);
    stc(32'h100, 2'd3, 1'b1, 1'b1, "R8 snoop in granule");
    ld(32'h100, 2'd3, 1'b1); snoop(32'h108);
    stc(32'h100, 2'd3, 1'b1, 1'b0, "R8 snoop outside granule");
    ld(32'h100, 2'd2, 1'b1);
    op(1'b1, 32'h100, 2'd2, 1'b1, 1'b1, 32'h102, 1'b0);
    expect_resp(1'b1, "R8 snoop with store");
    ld(32'h100, 2'd2, 1'b1); op(1'b0, 32'h0, 2'd0, 1'b0, 1'b0, 32'h0, 1'b1);
    stc(32'h100, 2'd2, 1'b1, 1'b1, "R9 clear then store");
    op(1'b0, 32'h100, 2'd2, 1'b1, 1'b0, 32'h0, 1'b1);
    stc(32'h100, 2'd2, 1'b1, 1'b1, "R9 clear with load");
    ld(32'h100, 2'd2, 1'b1);
    op(1'b1, 32'h100, 2'd2, 1'b1, 1'b0, 32'h0, 1'b1);
    expect_resp(1'b1, "R9 clear with store");
    ld(32'h104, 2'd3, 1'b1); stc(32'h104, 2'd3, 1'b1, 1'b1, "R11 misaligned dword");
    ld(32'h101, 2'd1, 1'b0); stc(32'h101, 2'd1, 1'b0, 1'b1, "R11 misaligned half");

    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      req_valid  = ($urandom % 3) != 0;
      req_store  = $urandom % 2;
      case ($urandom % 5)
        0: req_addr = 32'h100;
        1: req_addr = 32'h104;
        2: req_addr = 32'h108;
        3: req_addr = 32'h102;
        default: req_addr = 32'h101;
      endcase
      req_size    = ($urandom % 2) ? 2'd2 : 2'($urandom % 4);
      req_shared  = ($urandom % 4) != 0;
      snoop_valid = ($urandom % 6) == 0;
      snoop_addr  = 32'h100 + 32'($urandom % 16);
      clr_excl    = ($urandom % 25) == 0;
    end
    @(negedge clk);
    req_valid = 1'b0; snoop_valid = 1'b0; clr_excl = 1'b0;
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule